// File: doc/BRIEF.md
# I2C Master Transaction Sequencer

This block runs whole I2C master transactions from descriptors held in a small local byte memory. Software fills the memory through a simple write port. It then pulses `go` with a descriptor pointer and a direction bit. From that point the sequencer works on its own. It hands a stream of byte-level commands (start, write byte, read byte, stop) to a byte engine below it and waits for that engine's completion event before it sends the next command. SCL/SDA timing, clock stretching and arbitration are the byte engine's job.

A write descriptor holds the target address, a byte count N and then N data bytes. A read descriptor holds only the address and N. Received bytes go into a local receive buffer that software reads through a combinational port. A read ends in a held data-ready state, which software clears with `ready_ack`. Each read byte carries the master's acknowledge decision, and that decision is fixed when the read command is issued, before the byte arrives. Any slave NACK ends the transfer with a stop and an error code that names the phase where it happened.

The memory depth must be a power of two so that descriptor addresses wrap. The receive depth must not exceed 255.

Top module: `i2c_desc_seq`

## Requirements
- R1: The first byte written after the start has the 7-bit target address in bits 7:1 and the direction in bit 0: 1 for a read, 0 for a write.
- R2: A descriptor at pointer P is laid out as follows. Byte P bits 6:0 give the target address, and bit 7 is ignored. Byte P+1 gives N. For a write, data byte k is at P+2+k. All addresses wrap modulo the memory depth.
- R3: Command codes on `cmd_op` are 0 start, 1 write byte, 2 read byte and 3 stop. `cmd_valid` pulses for one cycle per command. A new command is issued only after the previous command's `evt`, except the first. `cmd_byte` is 0 for start, read and stop. `cmd_nack` is 0 for everything except read.
- R4: If the address byte is NACKed, in either direction, the next command is a stop. `err` then pulses with `err_code` 1, no data command is issued, and the block returns to idle.
- R5: If a write data byte is NACKed, the next command is a stop. `err` then pulses with `err_code` 2 and the block returns to idle.
- R6: After the final write byte (index N-1) is ACKed, a stop is issued, `done` pulses and the block returns to idle. Otherwise the next data byte is written. `done` and `err` never pulse together.
- R7: Each read command carries `cmd_nack`=1 when it fetches byte N-1 (including N=1, issued straight after the address ACK), and 0 otherwise.
- R8: Received byte k is stored at receive index k, and `rx_count` counts the bytes received. After byte N-1 a stop is issued and `data_ready` stays high until `ready_ack`; the block then goes idle.
- R9: A descriptor with N=0, or a read with N greater than the receive depth, pulses `err` with `err_code` 3 and issues no command.
- R10: A `go` that arrives while `busy` is high (including the data-ready state) pulses `reject` in the next cycle and has no other effect.
- R11: After reset `busy`, `done`, `err`, `reject`, `data_ready` and `cmd_valid` are low, and `err_code` and `rx_count` are 0. `err_code` holds its value until the next accepted `go`.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| mem_we | input | 1 | Descriptor memory write enable |
| mem_waddr | input | AW | Descriptor memory write address |
| mem_wdata | input | 8 | Descriptor memory write data |
| go | input | 1 | Start a transaction |
| go_ptr | input | AW | Descriptor pointer |
| go_read | input | 1 | 1 for a read, 0 for a write |
| ready_ack | input | 1 | Software has taken the received data |
| cmd_valid | output | 1 | Command pulse to the byte engine |
| cmd_op | output | 2 | Command code |
| cmd_byte | output | 8 | Byte to transmit |
| cmd_nack | output | 1 | Master response for a read byte (1 = NACK) |
| evt | input | 1 | Byte engine completion pulse |
| evt_nack | input | 1 | Slave NACKed the written byte |
| evt_byte | input | 8 | Byte received by a read |
| rx_addr | input | RXW | Receive buffer read index |
| rx_byte | output | 8 | Receive buffer read data |
| busy | output | 1 | Transaction in progress or data ready |
| done | output | 1 | Write finished successfully (pulse) |
| data_ready | output | 1 | Read finished, data held |
| err | output | 1 | Transaction aborted (pulse) |
| err_code | output | 2 | 1 address NACK, 2 data NACK, 3 bad descriptor |
| reject | output | 1 | `go` ignored while busy (pulse) |
| rx_count | output | CW | Bytes received in the current read |

## Verification
The properties assume a byte engine with at most one command in flight. They also assume that `evt` never arrives without a preceding command and that `evt_nack` is low on completions of start and read commands. The bench's engine model meets these assumptions. It takes each command at a falling edge, answers three cycles later with a single-cycle `evt`, raises `evt_nack` only on the write byte chosen for the test, and never answers a stop. Descriptor memory is written only while the sequencer is idle, so the bytes it fetches cannot change during a transaction.

// File: rtl/i2c_desc_seq.sv
module i2c_desc_seq #(
  parameter int MEM_DEPTH = 16,
  parameter int RX_DEPTH  = 16,
  localparam int AW  = $clog2(MEM_DEPTH),
  localparam int RXW = $clog2(RX_DEPTH),
  localparam int CW  = $clog2(RX_DEPTH + 1)
) (
  input  logic           clk,
  input  logic           rst_n,
  input  logic           mem_we,
  input  logic [AW-1:0]  mem_waddr,
  input  logic [7:0]     mem_wdata,
  input  logic           go,
  input  logic [AW-1:0]  go_ptr,
  input  logic           go_read,
  input  logic           ready_ack,
  output logic           cmd_valid,
  output logic [1:0]     cmd_op,
  output logic [7:0]     cmd_byte,
  output logic           cmd_nack,
  input  logic           evt,
  input  logic           evt_nack,
  input  logic [7:0]     evt_byte,
  input  logic [RXW-1:0] rx_addr,
  output logic [7:0]     rx_byte,
  output logic           busy,
  output logic           done,
  output logic           data_ready,
  output logic           err,
  output logic [1:0]     err_code,
  output logic           reject,
  output logic [CW-1:0]  rx_count
);

  localparam logic [1:0] OP_START = 2'd0, OP_WRITE = 2'd1, OP_READ = 2'd2, OP_STOP = 2'd3;
  localparam logic [1:0] E_ADDR = 2'd1, E_DATA = 2'd2, E_DESC = 2'd3;
  localparam logic [8:0] RX_MAX = 9'(RX_DEPTH);

  typedef enum logic [2:0] {
    IDLE, RD_STA, RD_ADR, RD_BYTE, RD_RDY, WR_STA, WR_ADR, WR_BYTE
  } state_t;

  state_t        st;
  logic [7:0]    mem [MEM_DEPTH];
  logic [7:0]    rxb [RX_DEPTH];
  logic [AW-1:0] base, p1, dptr;
  logic [6:0]    tgt;
  logic [7:0]    n_q, idx, n_in, cnt_nx;
  logic          bad;

  assign p1     = go_ptr + AW'(1);
  assign n_in   = mem[p1];
  assign bad    = (n_in == 8'd0) || (go_read && ({1'b0, n_in} > RX_MAX));
  assign dptr   = base + AW'(2) + AW'(idx);
  assign cnt_nx = 8'(rx_count) + 8'd1;

  assign busy       = (st != IDLE);
  assign data_ready = (st == RD_RDY);
  assign rx_byte    = rxb[rx_addr];

  always_ff @(posedge clk) begin
    if (mem_we) mem[mem_waddr] <= mem_wdata;
  end

  always_ff @(posedge clk) begin
    if (st == RD_BYTE && evt) rxb[rx_count[RXW-1:0]] <= evt_byte;
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      st        <= IDLE;
      base      <= '0;
      tgt       <= '0;
      n_q       <= '0;
      idx       <= '0;
      cmd_valid <= 1'b0;
      cmd_op    <= OP_START;
      cmd_byte  <= '0;
      cmd_nack  <= 1'b0;
      done      <= 1'b0;
      err       <= 1'b0;
      err_code  <= '0;
      reject    <= 1'b0;
      rx_count  <= '0;
    end else begin
      cmd_valid <= 1'b0;
      done      <= 1'b0;
      err       <= 1'b0;
      reject    <= go && (st != IDLE);
      case (st)
        IDLE: if (go) begin
          err_code <= '0;
          rx_count <= '0;
          if (bad) begin
            err      <= 1'b1;
            err_code <= E_DESC;
          end else begin
            base      <= go_ptr;
            tgt       <= mem[go_ptr][6:0];
            n_q       <= n_in;
            idx       <= '0;
            cmd_valid <= 1'b1;
            cmd_op    <= OP_START;
            cmd_byte  <= '0;
            cmd_nack  <= 1'b0;
            st        <= go_read ? RD_STA : WR_STA;
          end
        end
        RD_STA, WR_STA: if (evt) begin
          cmd_valid <= 1'b1;
          cmd_op    <= OP_WRITE;
          cmd_byte  <= {tgt, st == RD_STA};
          cmd_nack  <= 1'b0;
          st        <= (st == RD_STA) ? RD_ADR : WR_ADR;
        end
        RD_ADR, WR_ADR: if (evt) begin
          cmd_valid <= 1'b1;
          cmd_nack  <= 1'b0;
          cmd_byte  <= '0;
          if (evt_nack) begin
            cmd_op   <= OP_STOP;
            err      <= 1'b1;
            err_code <= E_ADDR;
            st       <= IDLE;
          end else if (st == RD_ADR) begin
            cmd_op   <= OP_READ;
            cmd_nack <= (n_q == 8'd1);
            st       <= RD_BYTE;
          end else begin
            cmd_op   <= OP_WRITE;
            cmd_byte <= mem[dptr];
            st       <= WR_BYTE;
          end
        end
        RD_BYTE: if (evt) begin
          rx_count  <= rx_count + CW'(1);
          cmd_valid <= 1'b1;
          cmd_byte  <= '0;
          if (cnt_nx == n_q) begin
            cmd_op   <= OP_STOP;
            cmd_nack <= 1'b0;
            st       <= RD_RDY;
          end else begin
            cmd_op   <= OP_READ;
            cmd_nack <= (cnt_nx + 8'd1 == n_q);
          end
        end
        RD_RDY: if (ready_ack) st <= IDLE;
        WR_BYTE: if (evt) begin
          cmd_valid <= 1'b1;
          cmd_nack  <= 1'b0;
          if (evt_nack) begin
            cmd_op   <= OP_STOP;
            cmd_byte <= '0;
            err      <= 1'b1;
            err_code <= E_DATA;
            st       <= IDLE;
          end else if (idx == n_q - 8'd1) begin
            cmd_op   <= OP_STOP;
            cmd_byte <= '0;
            done     <= 1'b1;
            st       <= IDLE;
          end else begin
            idx      <= idx + 8'd1;
            cmd_op   <= OP_WRITE;
            cmd_byte <= mem[dptr + AW'(1)];
          end
        end
        default: st <= IDLE;
      endcase
    end
  end

endmodule

// File: rtl/i2c_desc_seq_chk.sv
module i2c_desc_seq_chk (
  input logic       clk,
  input logic       rst_n,
  input logic       go,
  input logic       busy,
  input logic       reject,
  input logic       evt,
  input logic       evt_nack,
  input logic       cmd_valid,
  input logic [1:0] cmd_op,
  input logic       cmd_nack,
  input logic       done,
  input logic       err,
  input logic       data_ready,
  input logic       ready_ack,
  input logic [7:0] rx_cnt,
  input logic [7:0] n_q,
  input logic       ack_wait
);

  assert_busy_reject_R10: assert property (@(posedge clk) disable iff (!rst_n)
    go && busy |=> reject);

  // R4 and R5: a slave NACK on any written byte aborts with a stop
  assert_nack_abort_R5: assert property (@(posedge clk) disable iff (!rst_n)
    evt && evt_nack && ack_wait |=> cmd_valid && cmd_op == 2'd3 && err && !busy);

  assert_last_read_nack_R7: assert property (@(posedge clk) disable iff (!rst_n)
    cmd_valid && cmd_op == 2'd2 |-> cmd_nack == (rx_cnt + 8'd1 == n_q));

  assert_done_exclusive_R6: assert property (@(posedge clk) disable iff (!rst_n)
    $onehot0({done, err}));

  assert_done_idle_R6: assert property (@(posedge clk) disable iff (!rst_n)
    done |-> !busy);

  assert_ready_hold_R8: assert property (@(posedge clk) disable iff (!rst_n)
    data_ready && !ready_ack |=> data_ready);

endmodule

bind i2c_desc_seq i2c_desc_seq_chk chk_i (
  .clk        (clk),
  .rst_n      (rst_n),
  .go         (go),
  .busy       (busy),
  .reject     (reject),
  .evt        (evt),
  .evt_nack   (evt_nack),
  .cmd_valid  (cmd_valid),
  .cmd_op     (cmd_op),
  .cmd_nack   (cmd_nack),
  .done       (done),
  .err        (err),
  .data_ready (data_ready),
  .ready_ack  (ready_ack),
  .rx_cnt     (8'(rx_count)),
  .n_q        (n_q),
  .ack_wait   (st == WR_ADR || st == RD_ADR || st == WR_BYTE)
);

// File: tb/i2c_desc_seq_tb_top.sv
module i2c_desc_seq_tb_top;
  localparam int AW = 4, RXW = 4, CW = 5;

  logic clk = 1'b0, rst_n = 1'b0;
  logic mem_we = 0, go = 0, go_read = 0, ready_ack = 0;
  logic [AW-1:0] mem_waddr = '0, go_ptr = '0;
  logic [7:0] mem_wdata = '0;
  logic cmd_valid, cmd_nack, busy, done, data_ready, err, reject;
  logic [1:0] cmd_op, err_code;
  logic [7:0] cmd_byte, rx_byte;
  logic evt = 0, evt_nack = 0;
  logic [7:0] evt_byte = '0;
  logic [RXW-1:0] rx_addr = '0;
  logic [CW-1:0] rx_count;

  int checks = 0, errors = 0;
  logic [10:0] exp_q [$];
  int n_done = 0, n_err = 0, n_rej = 0;
  logic [1:0] last_code = '0;
  int nack_at = -1, byte_no = 0, rd_k = 0;
  logic [7:0] rd_base = 8'h00;
  logic [7:0] wbuf [16];
  logic [1:0] eop;
  bit finished = 0;

  always #5 clk = ~clk;

  i2c_desc_seq dut_i (
    .clk(clk), .rst_n(rst_n), .mem_we(mem_we), .mem_waddr(mem_waddr), .mem_wdata(mem_wdata),
    .go(go), .go_ptr(go_ptr), .go_read(go_read), .ready_ack(ready_ack),
    .cmd_valid(cmd_valid), .cmd_op(cmd_op), .cmd_byte(cmd_byte), .cmd_nack(cmd_nack),
    .evt(evt), .evt_nack(evt_nack), .evt_byte(evt_byte), .rx_addr(rx_addr), .rx_byte(rx_byte),
    .busy(busy), .done(done), .data_ready(data_ready), .err(err), .err_code(err_code),
    .reject(reject), .rx_count(rx_count)
  );

  task automatic check(input bit ok, input string tag, input logic [31:0] act, input logic [31:0] exp);
    checks++;
    if (!ok) begin
      errors++;
      $display("FAIL %s actual=%0h expected=%0h", tag, act, exp);
    end
  endtask

  // scoreboard monitor: every command must match the next expected one (R1, R3, R7)
  always @(negedge clk) begin
    if (rst_n && cmd_valid) begin
      if (exp_q.size() == 0) check(0, "R3 unexpected command", {cmd_op, cmd_nack, cmd_byte}, 0);
      else begin
        logic [10:0] e;
        e = exp_q.pop_front();
        check({cmd_op, cmd_nack, cmd_byte} == e, "R3 command stream", {cmd_op, cmd_nack, cmd_byte}, e);
      end
    end
    if (done) n_done++;
    if (err) begin n_err++; last_code = err_code; end
    if (reject) n_rej++;
  end

  // behavioural byte engine
  initial begin
    wait (rst_n);
    @(negedge clk);
    forever begin
      if (cmd_valid) begin
        eop = cmd_op;
        if (eop == 2'd3) @(negedge clk);
        else begin
          if (eop == 2'd0) begin byte_no = 0; rd_k = 0; end
          repeat (3) @(negedge clk);
          evt_nack = (eop == 2'd1) && (byte_no == nack_at);
          evt_byte = (eop == 2'd2) ? rd_base + 8'(rd_k) : 8'h00;
          if (eop == 2'd1) byte_no++;
          if (eop == 2'd2) rd_k++;
          evt = 1'b1;
          @(negedge clk);
          evt = 1'b0;
          evt_nack = 1'b0;
        end
      end else @(negedge clk);
    end
  end

  task automatic mem_wr(input int a, input logic [7:0] d);
    @(negedge clk);
    mem_we = 1; mem_waddr = AW'(a); mem_wdata = d;
    @(negedge clk);
    mem_we = 0;
  endtask

  task automatic pulse_go(input int ptr, input bit rd);
    @(negedge clk);
    go = 1; go_ptr = AW'(ptr); go_read = rd;
    @(negedge clk);
    go = 0;
  endtask

  task automatic wait_settle();
    for (int i = 0; i < 3000; i++) begin
      @(negedge clk);
      if (!busy || data_ready) break;
    end
    @(negedge clk);
  endtask

  task automatic clear_seen();
    n_done = 0; n_err = 0; n_rej = 0;
  endtask

  task automatic push(input logic [1:0] op, input bit nk, input logic [7:0] b);
    exp_q.push_back({op, nk, b});
  endtask

  task automatic run_write(input int ptr, input logic [7:0] abyte, input int n, input int nack_v, input bit poke, input string tag);
    int code;
    mem_wr(ptr, abyte);
    mem_wr(ptr + 1, 8'(n));
    for (int k = 0; k < n; k++) mem_wr((ptr + 2 + k) % 16, wbuf[k]);
    push(2'd0, 0, 8'h00);
    push(2'd1, 0, {abyte[6:0], 1'b0});
    if (nack_v != 0)
      for (int k = 0; k < n; k++) begin
        push(2'd1, 0, wbuf[k]);
        if (nack_v == k + 1) break;
      end
    push(2'd3, 0, 8'h00);
    code = (nack_v == 0) ? 1 : ((nack_v >= 1 && nack_v <= n) ? 2 : 0);
    nack_at = nack_v;
    clear_seen();
    pulse_go(ptr, 0);
    if (poke) begin
      repeat (4) @(negedge clk);
      pulse_go((ptr + 3) % 16, 1);
      repeat (2) @(negedge clk);
      check(n_rej == 1, "R10 reject while busy", n_rej, 1);
    end
    wait_settle();
    check(exp_q.size() == 0, {tag, " all commands seen"}, exp_q.size(), 0);
    check(busy == 0, {tag, " idle after write"}, busy, 0);
    check(n_done == (code == 0 ? 1 : 0), {tag, " done pulse"}, n_done, code == 0);
    check(n_err == (code == 0 ? 0 : 1), {tag, " err pulse"}, n_err, code != 0);
    if (code != 0) check(err_code == 2'(code), {tag, " err_code"}, err_code, code);
    exp_q.delete();
  endtask

  task automatic run_read(input int ptr, input logic [7:0] abyte, input int n, input bit nack_a, input string tag);
    mem_wr(ptr, abyte);
    mem_wr(ptr + 1, 8'(n));
    push(2'd0, 0, 8'h00);
    push(2'd1, 0, {abyte[6:0], 1'b1});
    if (!nack_a) for (int k = 0; k < n; k++) push(2'd2, k == n - 1, 8'h00);
    push(2'd3, 0, 8'h00);
    nack_at = nack_a ? 0 : -1;
    rd_base = 8'h30 + 8'(n);
    clear_seen();
    pulse_go(ptr, 1);
    wait_settle();
    check(exp_q.size() == 0, {tag, " all commands seen"}, exp_q.size(), 0);
    if (nack_a) begin
      check(n_err == 1 && err_code == 2'd1, "R4 read address NACK error", {n_err[7:0], 6'b0, err_code}, 1);
      check(busy == 0 && data_ready == 0, "R4 idle after address NACK", {busy, data_ready}, 0);
    end else begin
      check(data_ready == 1 && busy == 1, "R8 data ready held", {data_ready, busy}, 3);
      check(rx_count == CW'(n), "R8 rx_count", rx_count, n);
      for (int k = 0; k < n; k++) begin
        rx_addr = RXW'(k);
        #1;
        check(rx_byte == rd_base + 8'(k), "R8 received byte", rx_byte, rd_base + 8'(k));
      end
      repeat (5) @(negedge clk);
      check(data_ready == 1, "R8 still ready without ack", data_ready, 1);
      pulse_go(ptr, 0);
      repeat (3) @(negedge clk);
      check(n_rej == 1 && data_ready == 1, "R10 go rejected in data-ready", n_rej, 1);
      @(negedge clk);
      ready_ack = 1;
      @(negedge clk);
      ready_ack = 0;
      check(busy == 0 && data_ready == 0, "R8 idle after ready_ack", {busy, data_ready}, 0);
    end
    exp_q.delete();
  endtask

  task automatic run_bad(input int ptr, input int n, input bit rd, input string tag);
    mem_wr(ptr, 8'h12);
    mem_wr(ptr + 1, 8'(n));
    clear_seen();
    pulse_go(ptr, rd);
    repeat (6) @(negedge clk);
    check(n_err == 1 && err_code == 2'd3, {tag, " descriptor error"}, {n_err[7:0], 6'b0, err_code}, 3);
    check(busy == 0, {tag, " no activity"}, busy, 0);
  endtask

  initial begin
    repeat (3) @(negedge clk);
    // R11 reset state
    check({busy, done, err, reject, data_ready, cmd_valid} == 6'b0, "R11 reset outputs", {busy, done, err, reject, data_ready, cmd_valid}, 0);
    check(err_code == 0 && rx_count == 0, "R11 reset code/count", {err_code, rx_count}, 0);
    rst_n = 1;
    repeat (2) @(negedge clk);

    wbuf[0] = 8'h42; wbuf[1] = 8'h10; wbuf[2] = 8'hA5; wbuf[3] = 8'h3C;
    run_write(0, 8'h2A, 3, -1, 0, "R6 write three");
    run_write(4, 8'hD5, 1, -1, 0, "R2 write one, bit7 ignored R1");
    run_write(14, 8'h11, 4, -1, 0, "R2 wrapped descriptor");
    run_write(0, 8'h33, 4, -1, 1, "R10 write with busy go");
    run_write(2, 8'h50, 3, 0, 0, "R4 write address NACK");
    run_write(6, 8'h61, 4, 2, 0, "R5 write data NACK");
    check(last_code == 2'd2, "R11 err_code held after error", last_code, 2);
    run_read(8, 8'h48, 1, 0, "R7 read one");
    run_read(0, 8'h19, 4, 0, "R7 read four");
    run_read(10, 8'h77, 16, 0, "R8 read full buffer");
    run_read(4, 8'h05, 3, 1, "R4 read address NACK");
    run_bad(12, 0, 0, "R9 N=0");
    run_bad(12, 17, 1, "R9 read too long");

    if (!finished) begin
      finished = 1;
      $display("CHECKS %0d ERRORS %0d", checks, errors);
      $finish;
    end
  end

  initial begin
    repeat (200000) @(posedge clk);
    if (!finished) begin
      finished = 1;
      checks++; errors++;
      $display("FAIL watchdog actual=running expected=finished");
      $display("CHECKS %0d ERRORS %0d", checks, errors);
      $finish;
    end
  end
endmodule